// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block walks the elements of a single vector operation and hands out one (element, sub-element) index pair per clock. When a start request arrives while the block is idle, it captures the vector length, the sub-vector length code, the predicate mode and selector, the three integer predicate registers and the per-element condition flags. From these it forms an element-enable mask and then issues every enabled element in ascending order. Each enabled element is issued once for each of its sub-elements. Disabled elements are skipped without spending any cycles.

Two predicate sources are supported. In integer mode a 3-bit selector tests a single index or a bit of one of three integer registers, either as written or inverted. In condition mode the same selector picks one of four per-element flags and chooses its set or clear sense. A single-cycle done pulse closes every accepted operation, including operations that issue nothing. Downstream execution logic consumes the index stream and uses done to retire the operation.

Top module: `pred_loop_seq`

## Requirements
- R1: For each enabled element the block issues sub-element indices 0 up to the sub-vector code (code 00..11 means lengths 1..4), one per cycle with the same element index, before it moves on to a higher element. Elements are issued in strictly ascending order.
- R2: With mode 0, selector 010/011 enables element i when bit i of r3 is set/clear, 100/101 does the same with r10, and 110/111 does the same with r30.
- R3: With mode 0 and selector 001, only the element whose index equals the full 64-bit r3 value is enabled. If r3 is not below VL, nothing is issued.
- R4: With mode 0 and selector 000, every element below VL is enabled.
- R5: With mode 1 the flags of element i sit at cr_flags[4i+3]=LT, [4i+2]=GT, [4i+1]=EQ, [4i]=SO. Selector bits [2:1] pick 00=LT, 01=GT, 10=EQ, 11=SO, and selector bit 0 set means the element is enabled when that flag is clear.
- R6: The first issue appears in the cycle after start is accepted. Later issues follow in back-to-back cycles, so skipped elements cost no cycles.
- R7: done is high for exactly one cycle, in the cycle right after the last issue, and never while valid is high.
- R8: When VL is 0 or no element is enabled, nothing is issued and done pulses in the cycle after start.
- R9: Every input that affects the loop is sampled only in the accepting cycle. Changes during the loop do not affect the issued stream.
- R10: A start request while the block is busy is ignored.
- R11: VL ranges from 0 to 64, and elements at or above VL are never issued, even when their predicate bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation (taken only when idle) |
| vl | input | 7 | Vector length, 0..64 |
| subvl | input | 2 | Sub-vector length code (length minus one) |
| mask_mode | input | 1 | 0 selects integer predication, 1 selects condition-flag predication |
| mask_sel | input | 3 | Predicate selector |
| r3 | input | 64 | Integer predicate register value r3 |
| r10 | input | 64 | Integer predicate register value r10 |
| r30 | input | 64 | Integer predicate register value r30 |
| cr_flags | input | 256 | Four flags per element, LT GT EQ SO from high to low |
| valid | output | 1 | An index pair is issued this cycle |
| elem_idx | output | 6 | Element index |
| sub_idx | output | 2 | Sub-element index |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench pushes the expected index stream for each operation, built from its own predicate model, and compares it against what the block issues. It also times each operation from start to done. Sparse masks with long gaps are used to catch a sequencer that burns a cycle per skipped element, and a selector-001 value beyond VL is used to catch a single-element compare that wraps or truncates r3. Full-length VL=64 runs with the top register bit set expose off-by-one errors in the length limit. Empty masks and VL=0 expose a design that hangs without done or issues a stray element. A start pulse during a loop, together with scrambled inputs after acceptance, catches designs that restart or recompute the mask on the fly.

// File: rtl/pls_pkg.sv
package pls_pkg;
  // Position of each condition flag inside an element's 4-bit group.
  typedef enum logic [1:0] {
    FLG_SO = 2'd0,
    FLG_EQ = 2'd1,
    FLG_GT = 2'd2,
    FLG_LT = 2'd3
  } cr_flag_e;

  // Selector bits [2:1] name LT, GT, EQ, SO in that order.
  function automatic cr_flag_e sel_to_flag(input logic [1:0] pair);
    return cr_flag_e'(~pair);
  endfunction
endpackage

// File: rtl/pls_mask_gen.sv
module pls_mask_gen
  import pls_pkg::*;
#(
  parameter int N    = 64,
  parameter int XLEN = 64,
  parameter int VLW  = 7
) (
  input  logic [VLW-1:0]  vl,
  input  logic            mask_mode,
  input  logic [2:0]      mask_sel,
  input  logic [XLEN-1:0] r3,
  input  logic [XLEN-1:0] r10,
  input  logic [XLEN-1:0] r30,
  input  logic [4*N-1:0]  cr_flags,
  output logic [N-1:0]    mask
);
  cr_flag_e flag_pick;
  assign flag_pick = sel_to_flag(mask_sel[2:1]);

  for (genvar i = 0; i < N; i++) begin : g_elem
    logic [3:0] flags;
    logic       int_en;
    logic       cr_en;
    assign flags = cr_flags[4*i +: 4];

    always_comb begin
      unique case (mask_sel[2:1])
        2'b00:   int_en = mask_sel[0] ? (r3 == XLEN'(i)) : 1'b1;
        2'b01:   int_en = r3[i]  ^ mask_sel[0];
        2'b10:   int_en = r10[i] ^ mask_sel[0];
        default: int_en = r30[i] ^ mask_sel[0];
      endcase
      cr_en = flags[flag_pick] ^ mask_sel[0];
    end

    assign mask[i] = (VLW'(i) < vl) && (mask_mode ? cr_en : int_en);
  end
endmodule

// File: rtl/pls_first_set.sv
module pls_first_set #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/pred_loop_seq.sv
module pred_loop_seq #(
  parameter int MAX_VL = 64,
  parameter int XLEN   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(MAX_VL+1)-1:0] vl,
  input  logic [1:0]                subvl,
  input  logic                      mask_mode,
  input  logic [2:0]                mask_sel,
  input  logic [XLEN-1:0]           r3,
  input  logic [XLEN-1:0]           r10,
  input  logic [XLEN-1:0]           r30,
  input  logic [4*MAX_VL-1:0]       cr_flags,
  output logic                      valid,
  output logic [$clog2(MAX_VL)-1:0] elem_idx,
  output logic [1:0]                sub_idx,
  output logic                      done
);
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int IW  = $clog2(MAX_VL);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [IW-1:0]     elem_q, elem_d;
  logic [1:0]        sub_q, sub_d;
  logic [1:0]        subvl_q, subvl_d;
  logic [MAX_VL-1:0] mask_q, mask_d;
  logic [MAX_VL-1:0] mask_new, above, search_vec;
  logic              hit;
  logic [IW-1:0]     hit_idx;

  pls_mask_gen #(.N(MAX_VL), .XLEN(XLEN), .VLW(VLW)) u_mask (
    .vl(vl), .mask_mode(mask_mode), .mask_sel(mask_sel),
    .r3(r3), .r10(r10), .r30(r30), .cr_flags(cr_flags), .mask(mask_new)
  );

  for (genvar i = 0; i < MAX_VL; i++) begin : g_above
    assign above[i] = (IW'(i) > elem_q);
  end

  assign search_vec = busy_q ? (mask_q & above) : mask_new;

  pls_first_set #(.N(MAX_VL), .IW(IW)) u_find (
    .vec(search_vec), .found(hit), .idx(hit_idx)
  );

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    elem_d  = elem_q;
    sub_d   = sub_q;
    subvl_d = subvl_q;
    mask_d  = mask_q;
    if (busy_q) begin
      if (sub_q != subvl_q) begin
        sub_d = sub_q + 2'd1;
      end else if (hit) begin
        elem_d = hit_idx;
        sub_d  = '0;
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      mask_d  = mask_new;
      subvl_d = subvl;
      sub_d   = '0;
      if (hit) begin
        busy_d = 1'b1;
        elem_d = hit_idx;
      end else begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      elem_q  <= '0;
      sub_q   <= '0;
      subvl_q <= '0;
      mask_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      elem_q  <= elem_d;
      sub_q   <= sub_d;
      subvl_q <= subvl_d;
      mask_q  <= mask_d;
    end
  end

  assign valid    = busy_q;
  assign elem_idx = elem_q;
  assign sub_idx  = sub_q;
  assign done     = done_q;
endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
  parameter int MAX_VL = 64,
  parameter int XLEN   = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic [$clog2(MAX_VL+1)-1:0] vl,
  input logic [1:0]                  subvl,
  input logic                        mask_mode,
  input logic [2:0]                  mask_sel,
  input logic [XLEN-1:0]             r3,
  input logic [XLEN-1:0]             r10,
  input logic [XLEN-1:0]             r30,
  input logic [4*MAX_VL-1:0]         cr_flags,
  input logic                        valid,
  input logic [$clog2(MAX_VL)-1:0]   elem_idx,
  input logic [1:0]                  sub_idx,
  input logic                        done
);
  localparam int VLW = $clog2(MAX_VL + 1);

  logic [1:0]     cap_subvl;
  logic [VLW-1:0] cap_vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_subvl <= '0;
      cap_vl    <= '0;
    end else if (start && !valid) begin
      cap_subvl <= subvl;
      cap_vl    <= vl;
    end
  end

  assert_sub_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> sub_idx <= cap_subvl);
  assert_sub_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && sub_idx != 2'd0) |->
      (elem_idx == $past(elem_idx) && sub_idx == 2'($past(sub_idx) + 2'd1)));
  assert_elem_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && sub_idx == 2'd0) |->
      (elem_idx > $past(elem_idx) && $past(sub_idx) == cap_subvl));
  assert_elem_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> VLW'(elem_idx) < cap_vl);
  assert_first_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(start) && sub_idx == 2'd0));
  assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);
  assert_done_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> done);
  assert_vl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid && vl == '0) |=> (done && !valid));
endmodule

bind pred_loop_seq pls_checker #(.MAX_VL(MAX_VL), .XLEN(XLEN)) u_chk (.*);

// File: tb/tb_pred_loop_seq.sv
`timescale 1ns/1ps
module tb_pred_loop_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [6:0]   vl;
  logic [1:0]   subvl;
  logic         mask_mode;
  logic [2:0]   mask_sel;
  logic [63:0]  r3, r10, r30;
  logic [255:0] cr_flags;
  logic         valid;
  logic [5:0]   elem_idx;
  logic [1:0]   sub_idx;
  logic         done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  pred_loop_seq dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Predicate model written from the requirements.
  function automatic bit enabled(input int i, input logic m, input logic [2:0] s,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
      input logic [255:0] f);
    bit e;
    if (!m) begin
      case (s[2:1])
        2'b00:   e = s[0] ? (a == 64'(i)) : 1'b1;
        2'b01:   e = a[i] ^ s[0];
        2'b10:   e = b[i] ^ s[0];
        default: e = c[i] ^ s[0];
      endcase
    end else begin
      case (s[2:1])
        2'b00:   e = f[4*i+3] ^ s[0];
        2'b01:   e = f[4*i+2] ^ s[0];
        2'b10:   e = f[4*i+1] ^ s[0];
        default: e = f[4*i]   ^ s[0];
      endcase
    end
    return e;
  endfunction

  // Monitor: compare every issue against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected issue elem", elem_idx, -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check({elem_idx, sub_idx} == e, "R1", "issue {elem,sub}",
              {elem_idx, sub_idx}, e);
      end
    end
  end

  task automatic run_op(input string req, input int n_vl, input logic [1:0] sv,
      input logic m, input logic [2:0] s, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [255:0] f,
      input bit poke);
    int exp_n = 0;
    int cyc;
    for (int i = 0; i < n_vl; i++) begin
      if (enabled(i, m, s, a, b, c, f)) begin
        for (int k = 0; k <= sv; k++) begin
          exp_q.push_back({6'(i), 2'(k)});
          exp_n++;
        end
      end
    end
    @(negedge clk);
    vl = 7'(n_vl); subvl = sv; mask_mode = m; mask_sel = s;
    r3 = a; r10 = b; r30 = c; cr_flags = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble every loop input once the start is accepted.
    vl = 7'd64; subvl = ~sv; mask_mode = ~m; mask_sel = ~s;
    r3 = ~a; r10 = ~b; r30 = ~c; cr_flags = ~f;
    cyc = 1;
    while (!done && cyc < 400) begin
      // R10: a second start with VL=0 while busy must be ignored.
      if (poke && cyc == 2) begin
        start = 1'b1; vl = 7'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, req, "done seen (R7)", done, 1);
    check(cyc == exp_n + 1, req, "cycles start-to-done (R6)", cyc, exp_n + 1);
    check(exp_q.size() == 0, req, "issues missing (R9)", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !valid, req, "done one cycle (R7)", {done, valid}, 0);
  endtask

  initial begin
    int n = 0;
    while (n < 200000) begin
      @(posedge clk);
      n++;
    end
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [255:0] crp;
    rst_n = 1'b0; start = 1'b0; vl = '0; subvl = '0; mask_mode = 1'b0;
    mask_sel = '0; r3 = '0; r10 = '0; r30 = '0; cr_flags = '0;
    repeat (3) @(negedge clk);
    check(!valid && !done, "R7", "reset outputs", {valid, done}, 0);
    rst_n = 1'b1;

    run_op("R4", 5, 2'd0, 1'b0, 3'b000, 0, 0, 0, '0, 0);
    run_op("R1", 3, 2'd3, 1'b0, 3'b000, 0, 0, 0, '0, 0);
    run_op("R3", 8, 2'd1, 1'b0, 3'b001, 64'd4, 0, 0, '0, 0);
    run_op("R3", 8, 2'd1, 1'b0, 3'b001, 64'd9, 0, 0, '0, 0);
    run_op("R3", 64, 2'd0, 1'b0, 3'b001, 64'h1_0000_0000, 0, 0, '0, 0);
    run_op("R2", 8, 2'd0, 1'b0, 3'b010, 64'hB2, 0, 0, '0, 0);
    run_op("R2", 8, 2'd2, 1'b0, 3'b011, 64'hB2, 0, 0, '0, 0);
    run_op("R2", 20, 2'd0, 1'b0, 3'b100, 0, 64'h8_1001, 0, '0, 0);
    run_op("R2", 20, 2'd1, 1'b0, 3'b101, 0, 64'hF_FF7E, 0, '0, 0);
    run_op("R2", 64, 2'd0, 1'b0, 3'b110, 0, 0, 64'h8000_0000_0000_0001, '0, 0);
    run_op("R2", 64, 2'd0, 1'b0, 3'b111, 0, 0, 64'h7FFF_FFFF_FFFF_FFFE, '0, 0);
    crp = {32{8'h5C}} ^ {16{16'h1248}};
    for (int s = 0; s < 8; s++)
      run_op("R5", 16, 2'd2, 1'b1, 3'(s), 0, 0, 0, crp, 0);
    run_op("R8", 0, 2'd3, 1'b0, 3'b000, 0, 0, 0, '0, 0);
    run_op("R8", 12, 2'd1, 1'b0, 3'b010, 64'd0, 0, 0, '0, 0);
    run_op("R10", 6, 2'd1, 1'b0, 3'b000, 0, 0, 0, '0, 1);
    run_op("R9", 10, 2'd0, 1'b0, 3'b010, 64'h2A5, 0, 0, '0, 1);
    run_op("R11", 64, 2'd3, 1'b0, 3'b000, 0, 0, 0, '0, 0);
    run_op("R11", 10, 2'd0, 1'b0, 3'b110, 0, 0, '1, '0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule